// File: doc/BRIEF.md
# Interrupt Status and Mask Register

This block collects single-cycle event pulses from up to `NUM_SRC` sources into a sticky status register and gates them through a mask register. The result drives one active-low interrupt pin. A status bit records its event whatever the mask holds, so software can always see which sources fired. Masking only decides whether the interrupt pin reacts.

Both registers sit on a simple word-addressed read/write port. The status register is fully writable. Software clears a serviced source by writing 0 to its bit. Software can also raise any source by writing 1 to it, which provides interrupt testing without a real event. The mask register has its own address, and writing it never disturbs the status bits.

Top module: `irq_stat_mask`

## Requirements
- R1: After reset the status register reads 0x0000, the mask register reads 0x0000 and `irq_no` is 1 (deasserted).
- R2: A 1 on `ev_i[i]` at a rising clock edge sets status bit i at that edge, whatever mask bit i holds.
- R3: A set status bit stays set until a write to the status address carries 0 in that bit position.
- R4: A write to the status address (word address 3) loads the written value into every status bit that has no event in the same cycle. This sets or clears bits.
- R5: When an event on bit i and a status write of 0 to bit i occur in the same cycle, bit i is 1 afterwards.
- R6: A write to the mask address (word address 2) stores the written value, which then reads back at that address. Such a write leaves the status bits unchanged.
- R7: `irq_no` is 0 exactly when some bit is 1 in both the status and mask registers. It follows the stored registers with no extra cycle of delay.
- R8: Mask bit i gates only status bit i (bit positions correspond one to one).
- R9: A read from any address other than 2 or 3 returns 0x0000. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Word address for the read and the write |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data for `addr_i`, combinational |
| ev_i | input | NUM_SRC | Event pulses, one per source |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume that an event input is a plain level sampled at each clock edge. A pulse longer than one cycle simply keeps setting the bit. They also assume that write data and address are stable around the edge at which `wr_en_i` is sampled. The stimulus drives every input on the falling edge and returns events and the write strobe to 0 before each readback. This way every rising edge sees settled, well-defined values, and reads never coincide with a state change.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int STAT_ADDR = 3,
  parameter int MASK_ADDR = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              stat_we_o,
  output logic              mask_we_o
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] MaskA = ADDR_W'(MASK_ADDR);

  always_comb begin
    if (addr_i == StatA)      sel_o = SEL_STAT;
    else if (addr_i == MaskA) sel_o = SEL_MASK;
    else                      sel_o = SEL_NONE;
  end

  assign stat_we_o = wr_en_i && (sel_o == SEL_STAT);
  assign mask_we_o = wr_en_i && (sel_o == SEL_MASK);

  always_comb begin
    assert (!(stat_we_o && mask_we_o)) else $error("p_one_target_r9");
  end
endmodule

// File: rtl/irq_stat_cell.sv
module irq_stat_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic we_i,
  input  logic wd_i,
  output logic q_o
);
  // event dominates a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (ev_i) q_o <= 1'b1;
    else if (we_i) q_o <= wd_i;
  end

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> q_o);
  p_event_beats_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && we_i && !wd_i) |=> q_o);
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !we_i) |=> $stable(q_o));
  p_write_loads_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && we_i) |=> (q_o == $past(wd_i)));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wd_i,
  output logic [NUM_SRC-1:0] stat_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    irq_stat_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev_i[i]),
      .we_i   (we_i),
      .wd_i   (wd_i[i]),
      .q_o    (stat_o[i])
    );
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wd_i,
  output logic [NUM_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wd_i;
  end

  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int ADDR_W    = 5,
  parameter int STAT_ADDR = 3,
  parameter int MASK_ADDR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] ev_i,
  output logic               irq_no
);
  reg_sel_e           sel;
  logic               stat_we, mask_we;
  logic [NUM_SRC-1:0] stat_q, mask_q;

  irq_decode #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_dec (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .sel_o     (sel),
    .stat_we_o (stat_we),
    .mask_we_o (mask_we)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_i),
    .we_i   (stat_we),
    .wd_i   (wdata_i),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wd_i   (wdata_i),
    .mask_o (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = stat_q;
      SEL_MASK: rdata_o = mask_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_no = ~|(stat_q & mask_q);

  p_mask_wr_keeps_stat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we && ev_i == '0) |=> $stable(stat_q));
  p_no_mask_no_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> irq_no);
  p_unmapped_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE && ev_i == '0) |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

// File: tb/sim_irq_stat_mask.sv
`timescale 1ns/1ps
module sim_irq_stat_mask;
  localparam int N = 16;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_STAT = 5'd3;
  localparam logic [AW-1:0] A_MASK = 5'd2;
  localparam logic [AW-1:0] A_BAD  = 5'd7;

  typedef struct {
    logic [N-1:0] data;
    logic         irq;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  ev = '0;
  logic          irq_n;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  irq_stat_mask u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .ev_i    (ev),
    .irq_no  (irq_n)
  );

  // one bus/event cycle
  task automatic drive(input logic w, input logic [AW-1:0] a,
                       input logic [N-1:0] d, input logic [N-1:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev = e;
    @(posedge clk);
  endtask

  // idle readback; the expected item goes to the scoreboard
  task automatic expect_rd(input logic [AW-1:0] a, input logic [N-1:0] d,
                           input logic irq, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en = 1'b0; ev = '0; addr = a;
    it.data = d; it.irq = irq; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #3;
  endtask

  // monitor: compare away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        n_run++;
        if (rdata !== it.data || irq_n !== it.irq) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq_no=%b expected rdata=%h irq_no=%b",
                   it.tag, rdata, irq_n, it.data, it.irq);
        end
      end
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(A_STAT, 16'h0000, 1'b1, "R1 status");
    expect_rd(A_MASK, 16'h0000, 1'b1, "R1 mask");
    // R2 event recorded while masked
    drive(1'b0, A_STAT, '0, 16'h0020);
    expect_rd(A_STAT, 16'h0020, 1'b1, "R2 masked event");
    // R3 sticky across idle cycles
    repeat (4) drive(1'b0, A_STAT, '0, '0);
    expect_rd(A_STAT, 16'h0020, 1'b1, "R3 sticky");
    // R6 mask write keeps status, R7 irq asserts
    drive(1'b1, A_MASK, 16'h0020, '0);
    expect_rd(A_MASK, 16'h0020, 1'b0, "R6 mask readback");
    expect_rd(A_STAT, 16'h0020, 1'b0, "R6 R7 status kept, irq low");
    // R4 software clear
    drive(1'b1, A_STAT, 16'h0000, '0);
    expect_rd(A_STAT, 16'h0000, 1'b1, "R4 clear");
    // R4 software set on masked bits only
    drive(1'b1, A_STAT, 16'h8001, '0);
    expect_rd(A_STAT, 16'h8001, 1'b1, "R4 R7 sw set masked");
    // R8 enable bit 15 only
    drive(1'b1, A_MASK, 16'h8000, '0);
    expect_rd(A_STAT, 16'h8001, 1'b0, "R8 bit15 gate");
    // R5 event beats a write of 0 on bit 0
    drive(1'b1, A_STAT, 16'h0000, 16'h0001);
    expect_rd(A_STAT, 16'h0001, 1'b1, "R5 event wins");
    // R9 unmapped write and read
    drive(1'b1, A_BAD, 16'hFFFF, '0);
    expect_rd(A_BAD, 16'h0000, 1'b1, "R9 unmapped read");
    expect_rd(A_STAT, 16'h0001, 1'b1, "R9 status untouched");
    expect_rd(A_MASK, 16'h8000, 1'b1, "R9 mask untouched");
    // R2 R7 multi-bit events, all enabled
    drive(1'b1, A_MASK, 16'hFFFF, '0);
    drive(1'b0, A_STAT, '0, 16'hAAAA);
    expect_rd(A_STAT, 16'hAAAB, 1'b0, "R2 R7 multi events");
    // R8 complementary mask leaves irq idle
    drive(1'b1, A_MASK, 16'h5554, '0);
    expect_rd(A_MASK, 16'h5554, 1'b1, "R8 disjoint mask");
    // R7 one overlap bit asserts
    drive(1'b1, A_MASK, 16'h0001, '0);
    expect_rd(A_STAT, 16'hAAAB, 1'b0, "R7 single overlap");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule